// File: doc/BRIEF.md
# Trace Port Configuration Register Bank

This block holds the software-visible settings of a trace output unit. A plain synchronous register bus (address, write enable, write data, read enable, read data) reaches it. The block keeps:

- the parallel port widths the pins can carry, and the width now in use;
- the divider for the asynchronous baud clock;
- the output protocol;
- the formatter control and status words;
- two read-only integration words that show the live handshake lines of the trace sources.

Its configuration outputs drive the formatter and pin logic, which sit outside this block. A static tie-off input gives the widest port the board wires up. Width bits above that limit read as zero. Writes to the current width are checked against that masked view. While the parallel protocol is selected, the formatter control word shows a fixed value. It shows the stored value again once a serial protocol is chosen. There is no stream path, so all pins are plain level signals with no back-pressure.

A read is taken when `rd_en` is high at a clock edge. `rd_data` shows the value on the next cycle and holds it until the next read. Writes take effect at the edge where `wr_en` is high. A read and a write to the same address in the same cycle return the value from before the write.

Top module: `tpcfg_regbank`

## Requirements
- R1: After reset the registers read as follows: supported widths 0x0B (tie-off 3), current width 0x01, prescaler 0, protocol 0x1, formatter control 0x102, and `rd_data` 0.
- R2: Supported widths (offset 0x000) read as the stored mask ANDed with the tie-off mask. The tie-off `max_port_sel` values map as follows: 0 gives 0x1, 1 gives 0x3, 2 or 3 gives 0xB.
- R3: The supported width mask uses bit 0 for 1-bit, bit 1 for 2-bit and bit 3 for 4-bit. Only those three bits are stored; every other written bit is dropped.
- R4: A write to the current width (offset 0x004) takes effect only when the word has exactly one bit set and that bit is set in the supported readback. Any other write leaves the old value. `cur_port_size` always has exactly one bit set.
- R5: The prescaler (offset 0x010) stores bits [12:0] of a write. Bits [31:13] read as zero. `presc` shows the stored field.
- R6: The protocol (offset 0x0F0) stores bits [1:0], with 00 for parallel, 01 for serial Manchester, 10 for serial NRZ and 11 reserved. All other bits read as zero.
- R7: The formatter control word (offset 0x304) stores only bits 1, 4, 5, 6, 9, 10, 12 and 13. In a serial protocol, bit 8 reads 1 and bit 0 reads 0.
- R8: While the protocol is 00, the formatter control word and `fmt_ctrl` read 0x102. Writes are still stored, and they become visible when a serial protocol is selected.
- R9: The following read as fixed values: formatter status (0x300) reads 0x08, and the synchronization counter (0x308) reads 0. Unmapped or unaligned offsets read 0, and writes to them change nothing.
- R10: Bit 0 at offset 0xEF8 reads `src_valid_a | src_valid_b`. Bit 0 at offset 0xEF0 reads `fmt_ready`. Both are sampled at the read edge, and the other bits read 0.
- R11: `rd_data` changes only on the cycle after a read. A read in the same cycle as a write to the same address returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write word |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read word |
| max_port_sel | input | 2 | Static widest-port tie-off |
| src_valid_a | input | 1 | Valid line of trace source A |
| src_valid_b | input | 1 | Valid line of trace source B |
| fmt_ready | input | 1 | Ready presented to both sources |
| cur_port_size | output | 4 | One-hot port width in use |
| presc | output | PRESC_W | Baud divisor minus one |
| protocol | output | 2 | Selected output protocol |
| fmt_ctrl | output | 14 | Formatter control as seen by readers |

## Verification
The assertions check the following on every cycle:
- `fmt_ctrl` is fixed at 0x102 whenever the parallel protocol is active;
- the constant trigger-in and enable bits hold in a serial protocol;
- the current width stays one-hot, and multi-bit writes to it are refused;
- protocol and prescaler writes land a cycle later;
- `rd_data` holds between reads.

Other behaviours need their scenarios in the bench and cannot be seen by the assertions:
- the tie-off masking as the width limit changes;
- a stored formatter word reappearing after parallel mode is left;
- writes refused because their width is unsupported;
- the live integration readback;
- zero reads of unmapped and unaligned offsets.

// File: rtl/tpcfg_pkg.sv
package tpcfg_pkg;

  localparam int unsigned OFF_W = 12;

  localparam logic [OFF_W-1:0] OFF_SUP    = 12'h000;
  localparam logic [OFF_W-1:0] OFF_CUR    = 12'h004;
  localparam logic [OFF_W-1:0] OFF_PRESC  = 12'h010;
  localparam logic [OFF_W-1:0] OFF_PROTO  = 12'h0F0;
  localparam logic [OFF_W-1:0] OFF_STAT   = 12'h300;
  localparam logic [OFF_W-1:0] OFF_FMT    = 12'h304;
  localparam logic [OFF_W-1:0] OFF_SYNC   = 12'h308;
  localparam logic [OFF_W-1:0] OFF_IT_RDY = 12'hEF0;
  localparam logic [OFF_W-1:0] OFF_IT_VLD = 12'hEF8;

  typedef enum logic [1:0] {
    PROTO_PARALLEL = 2'b00,
    PROTO_SER_MAN  = 2'b01,
    PROTO_SER_NRZ  = 2'b10,
    PROTO_RSVD     = 2'b11
  } proto_e;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_SUP, SEL_CUR, SEL_PRESC, SEL_PROTO,
    SEL_STAT, SEL_FMT, SEL_SYNC, SEL_IT_RDY, SEL_IT_VLD
  } sel_e;

  localparam int unsigned SIZE_W = 4;
  localparam logic [SIZE_W-1:0] SIZE_LEGAL = 4'b1011;
  localparam logic [SIZE_W-1:0] SIZE_RST   = 4'b0001;

  localparam int unsigned FMT_W = 14;
  localparam logic [FMT_W-1:0] FMT_PARALLEL_VIEW = 14'h0102;
  localparam logic [FMT_W-1:0] FMT_STORE_MASK    = 14'h3672;
  localparam logic [FMT_W-1:0] FMT_STORE_RST     = 14'h0002;
  localparam logic [FMT_W-1:0] FMT_TRIGIN_BIT    = 14'h0100;

  localparam logic [3:0] STAT_VALUE = 4'h8;

  function automatic sel_e decode_off(input logic [OFF_W-1:0] off);
    case (off)
      OFF_SUP:    return SEL_SUP;
      OFF_CUR:    return SEL_CUR;
      OFF_PRESC:  return SEL_PRESC;
      OFF_PROTO:  return SEL_PROTO;
      OFF_STAT:   return SEL_STAT;
      OFF_FMT:    return SEL_FMT;
      OFF_SYNC:   return SEL_SYNC;
      OFF_IT_RDY: return SEL_IT_RDY;
      OFF_IT_VLD: return SEL_IT_VLD;
      default:    return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/tpcfg_field_reg.sv
module tpcfg_field_reg #(
  parameter int unsigned W = 13,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST;
    else if (we) q <= d;
  end
endmodule

// File: rtl/tpcfg_port_size.sv
module tpcfg_port_size
  import tpcfg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sup,
  input  logic              wr_cur,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        max_port_sel,
  output logic [SIZE_W-1:0] sup_rd,
  output logic [SIZE_W-1:0] cur
);
  logic [SIZE_W-1:0] sup_q;
  logic [SIZE_W-1:0] width_mask;
  logic              single_bit;
  logic              supported_hit;

  always_comb begin
    case (max_port_sel)
      2'd0:    width_mask = 4'b0001;
      2'd1:    width_mask = 4'b0011;
      default: width_mask = 4'b1011;
    endcase
  end

  assign sup_rd = sup_q & width_mask & SIZE_LEGAL;

  assign single_bit    = (wr_data != '0) && ((wr_data & (wr_data - DATA_W'(1))) == '0);
  assign supported_hit = |(wr_data[SIZE_W-1:0] & sup_rd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sup_q <= SIZE_LEGAL;
      cur   <= SIZE_RST;
    end else begin
      if (wr_sup) sup_q <= wr_data[SIZE_W-1:0] & SIZE_LEGAL;
      if (wr_cur && single_bit && supported_hit) cur <= wr_data[SIZE_W-1:0];
    end
  end
endmodule

// File: rtl/tpcfg_fmt_ctrl.sv
module tpcfg_fmt_ctrl
  import tpcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_proto,
  input  logic             wr_fmt,
  input  logic [FMT_W-1:0] wr_field,
  output proto_e           proto,
  output logic [FMT_W-1:0] fmt_eff
);
  logic [FMT_W-1:0] fmt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      proto <= PROTO_SER_MAN;
      fmt_q <= FMT_STORE_RST;
    end else begin
      if (wr_proto) proto <= proto_e'(wr_field[1:0]);
      if (wr_fmt)   fmt_q <= wr_field & FMT_STORE_MASK;
    end
  end

  assign fmt_eff = (proto == PROTO_PARALLEL) ? FMT_PARALLEL_VIEW
                                             : (fmt_q | FMT_TRIGIN_BIT);
endmodule

// File: rtl/tpcfg_read_mux.sv
module tpcfg_read_mux
  import tpcfg_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PRESC_W = 13
) (
  input  sel_e               sel,
  input  logic [SIZE_W-1:0]  sup_rd,
  input  logic [SIZE_W-1:0]  cur,
  input  logic [PRESC_W-1:0] presc,
  input  proto_e             proto,
  input  logic [FMT_W-1:0]   fmt_eff,
  input  logic               any_valid,
  input  logic               ready,
  output logic [DATA_W-1:0]  word
);
  always_comb begin
    word = '0;
    case (sel)
      SEL_SUP:    word = DATA_W'(sup_rd);
      SEL_CUR:    word = DATA_W'(cur);
      SEL_PRESC:  word = DATA_W'(presc);
      SEL_PROTO:  word = DATA_W'(proto);
      SEL_STAT:   word = DATA_W'(STAT_VALUE);
      SEL_FMT:    word = DATA_W'(fmt_eff);
      SEL_IT_RDY: word = DATA_W'(ready);
      SEL_IT_VLD: word = DATA_W'(any_valid);
      default:    word = '0;
    endcase
  end
endmodule

// File: rtl/tpcfg_regbank.sv
module tpcfg_regbank
  import tpcfg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PRESC_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [1:0]         max_port_sel,
  input  logic               src_valid_a,
  input  logic               src_valid_b,
  input  logic               fmt_ready,
  output logic [3:0]         cur_port_size,
  output logic [PRESC_W-1:0] presc,
  output logic [1:0]         protocol,
  output logic [13:0]        fmt_ctrl
);
  logic              hi_zero;
  sel_e              sel;
  logic [SIZE_W-1:0] sup_rd;
  proto_e            proto;
  logic [DATA_W-1:0] rd_word;

  generate
    if (ADDR_W > OFF_W) begin : g_wide_addr
      assign hi_zero = ~|addr[ADDR_W-1:OFF_W];
    end else begin : g_narrow_addr
      assign hi_zero = 1'b1;
    end
  endgenerate

  assign sel = hi_zero ? decode_off(addr[OFF_W-1:0]) : SEL_NONE;

  tpcfg_port_size #(.DATA_W(DATA_W)) u_size (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_sup       (wr_en && sel == SEL_SUP),
    .wr_cur       (wr_en && sel == SEL_CUR),
    .wr_data      (wr_data),
    .max_port_sel (max_port_sel),
    .sup_rd       (sup_rd),
    .cur          (cur_port_size)
  );

  tpcfg_field_reg #(.W(PRESC_W), .RST('0)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en && sel == SEL_PRESC),
    .d     (wr_data[PRESC_W-1:0]),
    .q     (presc)
  );

  tpcfg_fmt_ctrl u_fmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_proto (wr_en && sel == SEL_PROTO),
    .wr_fmt   (wr_en && sel == SEL_FMT),
    .wr_field (wr_data[FMT_W-1:0]),
    .proto    (proto),
    .fmt_eff  (fmt_ctrl)
  );

  assign protocol = proto;

  tpcfg_read_mux #(.DATA_W(DATA_W), .PRESC_W(PRESC_W)) u_rmux (
    .sel       (sel),
    .sup_rd    (sup_rd),
    .cur       (cur_port_size),
    .presc     (presc),
    .proto     (proto),
    .fmt_eff   (fmt_ctrl),
    .any_valid (src_valid_a | src_valid_b),
    .ready     (fmt_ready),
    .word      (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;
  end
endmodule

// File: rtl/tpcfg_regbank_chk.sv
module tpcfg_regbank_chk #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PRESC_W = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  addr,
  input logic               wr_en,
  input logic [DATA_W-1:0]  wr_data,
  input logic               rd_en,
  input logic [DATA_W-1:0]  rd_data,
  input logic [3:0]         cur_port_size,
  input logic [PRESC_W-1:0] presc,
  input logic [1:0]         protocol,
  input logic [13:0]        fmt_ctrl
);
  AST_FMT_PARALLEL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    protocol == 2'b00 |-> fmt_ctrl == 14'h0102); // R8
  AST_FMT_CONST_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_ctrl[8] && !fmt_ctrl[0]); // R7
  AST_CUR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cur_port_size) == 1); // R4
  AST_CUR_MULTI_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == ADDR_W'(12'h004) && $countones(wr_data) != 1
    |=> $stable(cur_port_size)); // R4
  AST_PROTO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == ADDR_W'(12'h0F0) |=> protocol == $past(wr_data[1:0])); // R6
  AST_PRESC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == ADDR_W'(12'h010) |=> presc == $past(wr_data[PRESC_W-1:0])); // R5
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R11
  AST_RD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == ADDR_W'(12'h300) |=> rd_data == DATA_W'(8)); // R9
endmodule

bind tpcfg_regbank tpcfg_regbank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRESC_W(PRESC_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .addr          (addr),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .rd_en         (rd_en),
  .rd_data       (rd_data),
  .cur_port_size (cur_port_size),
  .presc         (presc),
  .protocol      (protocol),
  .fmt_ctrl      (fmt_ctrl)
);

// File: tb/tpcfg_regbank_bench.sv
`timescale 1ns/1ps
module tpcfg_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [1:0]  max_port_sel = 2'd3;
  logic        src_valid_a = 1'b0;
  logic        src_valid_b = 1'b0;
  logic        fmt_ready = 1'b0;
  logic [3:0]  cur_port_size;
  logic [12:0] presc;
  logic [1:0]  protocol;
  logic [13:0] fmt_ctrl;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tpcfg_regbank u_tpcfg_regbank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .max_port_sel(max_port_sel),
    .src_valid_a(src_valid_a), .src_valid_b(src_valid_b), .fmt_ready(fmt_ready),
    .cur_port_size(cur_port_size), .presc(presc), .protocol(protocol),
    .fmt_ctrl(fmt_ctrl)
  );

  // behavioural reference model
  int          m_sup, m_cur, m_presc, m_proto, m_fmt;
  logic [31:0] m_rd;

  function automatic int width_limit(input logic [1:0] s);
    if (s == 2'd0) return 'h1;
    if (s == 2'd1) return 'h3;
    return 'hB;
  endfunction

  function automatic int fmt_view();
    if (m_proto == 0) return 'h102;
    return m_fmt | 'h100;
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    case (a)
      12'h000: return m_sup & width_limit(max_port_sel);
      12'h004: return m_cur;
      12'h010: return m_presc;
      12'h0F0: return m_proto;
      12'h300: return 32'h8;
      12'h304: return fmt_view();
      12'hEF0: return {31'b0, fmt_ready};
      12'hEF8: return {31'b0, src_valid_a | src_valid_b};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sup = 'hB; m_cur = 1; m_presc = 0; m_proto = 1; m_fmt = 'h2; m_rd = '0;
    end else begin
      if (rd_en) m_rd = model_read(addr);
      if (wr_en) begin
        case (addr)
          12'h000: m_sup = wr_data & 'hB;
          12'h004: if ($countones(wr_data) == 1 &&
                       (wr_data & (m_sup & width_limit(max_port_sel))) != 0)
                     m_cur = wr_data;
          12'h010: m_presc = wr_data & 'h1FFF;
          12'h0F0: m_proto = wr_data & 'h3;
          12'h304: m_fmt = wr_data & 'h3672;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 cur_port_size", {28'b0, cur_port_size}, m_cur);
      chk("R5 presc", {19'b0, presc}, m_presc);
      chk("R6 protocol", {30'b0, protocol}, m_proto);
      chk("R8 fmt_ctrl", {18'b0, fmt_ctrl}, fmt_view());
      chk("R11 rd_data", rd_data, m_rd);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk(tag, rd_data, exp);
  endtask

  task automatic rdwr(input logic [11:0] a, input logic [31:0] d,
                      input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk(tag, rd_data, exp);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    checks++; errors++;
    $display("FAIL R11 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd_data in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    // R1 reset values
    rd(12'h000, 32'hB, "R1 supported");
    rd(12'h004, 32'h1, "R1 current");
    rd(12'h010, 32'h0, "R1 prescaler");
    rd(12'h0F0, 32'h1, "R1 protocol");
    rd(12'h304, 32'h102, "R1 fmt control");
    // R9 fixed and unmapped
    rd(12'h300, 32'h8, "R9 status");
    rd(12'h308, 32'h0, "R9 sync counter");
    wr(12'h400, 32'hFFFF_FFFF);
    rd(12'h400, 32'h0, "R9 unmapped");
    rd(12'h302, 32'h0, "R9 unaligned");
    rd(12'hEE0, 32'h0, "R9 unmapped high");
    // R10 integration readback
    src_valid_a = 1'b1;
    rd(12'hEF8, 32'h1, "R10 valid a");
    src_valid_a = 1'b0; src_valid_b = 1'b1;
    rd(12'hEF8, 32'h1, "R10 valid b");
    src_valid_b = 1'b0;
    rd(12'hEF8, 32'h0, "R10 no valid");
    fmt_ready = 1'b1;
    rd(12'hEF0, 32'h1, "R10 ready high");
    fmt_ready = 1'b0;
    rd(12'hEF0, 32'h0, "R10 ready low");
    // R5 prescaler
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, 32'h1FFF, "R5 prescaler top bits");
    wr(12'h010, 32'h0000_0123);
    rd(12'h010, 32'h123, "R5 prescaler value");
    // R6 protocol
    wr(12'h0F0, 32'hFFFF_FFFE);
    rd(12'h0F0, 32'h2, "R6 protocol nrz");
    // R7 formatter control in serial mode
    wr(12'h304, 32'hFFFF_FFFF);
    rd(12'h304, 32'h3772, "R7 fmt all ones");
    wr(12'h304, 32'h0);
    rd(12'h304, 32'h100, "R7 fmt zero");
    // R8 parallel view
    wr(12'h304, 32'h1010);
    rd(12'h304, 32'h1110, "R8 stored before parallel");
    wr(12'h0F0, 32'h0);
    rd(12'h304, 32'h102, "R8 parallel view");
    wr(12'h304, 32'h2020);
    rd(12'h304, 32'h102, "R8 write while parallel");
    wr(12'h0F0, 32'h1);
    rd(12'h304, 32'h2120, "R8 stored after parallel");
    // R3 supported storage
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, 32'hB, "R3 supported legal bits");
    wr(12'h000, 32'h4);
    rd(12'h000, 32'h0, "R3 supported bit2 dropped");
    wr(12'h000, 32'hB);
    // R2 tie-off masking
    max_port_sel = 2'd0;
    rd(12'h000, 32'h1, "R2 tie-off 0");
    max_port_sel = 2'd1;
    rd(12'h000, 32'h3, "R2 tie-off 1");
    max_port_sel = 2'd2;
    rd(12'h000, 32'hB, "R2 tie-off 2");
    max_port_sel = 2'd3;
    // R4 current width
    wr(12'h004, 32'h8);
    rd(12'h004, 32'h8, "R4 accept 4-bit");
    wr(12'h004, 32'h3);
    rd(12'h004, 32'h8, "R4 reject two bits");
    wr(12'h004, 32'h4);
    rd(12'h004, 32'h8, "R4 reject illegal bit");
    wr(12'h004, 32'h0);
    rd(12'h004, 32'h8, "R4 reject zero");
    wr(12'h004, 32'h1_0000);
    rd(12'h004, 32'h8, "R4 reject high bit");
    wr(12'h004, 32'h2);
    rd(12'h004, 32'h2, "R4 accept 2-bit");
    max_port_sel = 2'd1;
    wr(12'h004, 32'h8);
    rd(12'h004, 32'h2, "R4 reject above tie-off");
    wr(12'h004, 32'h1);
    rd(12'h004, 32'h1, "R4 accept 1-bit");
    max_port_sel = 2'd3;
    wr(12'h000, 32'h1);
    wr(12'h004, 32'h2);
    rd(12'h004, 32'h1, "R4 reject unsupported");
    // R11 read/write collision and hold
    rdwr(12'h010, 32'h0000_0777, 32'h123, "R11 read before write");
    rd(12'h010, 32'h777, "R11 write landed");
    repeat (3) @(negedge clk);
    chk("R11 rd_data held", rd_data, 32'h777);
    finish_run();
  end
endmodule